// File: doc/BRIEF.md
# Circular Delay-Line Data Memory

This block is the data store of a small audio signal processor. It holds 2^AW words of DW bits (64 words of 16 bits by default) of two's-complement samples. A sequencer never supplies a physical address. Each request carries an offset, and the block adds that offset to a base pointer that moves forward by one on every sample tick. The sum wraps around the depth of the memory, so the storage behaves as a ring. A fixed offset therefore names a fixed delay tap: a word written at offset `o` can be read back `d` sample ticks later at offset `o - d`, modulo the depth.

An access is either single precision (one word) or double precision (two words on adjacent ring addresses). A double access takes two cycles on the single memory port. The memory reads before it writes, so a write request also hands back the contents it replaced. In a delay line, the newest sample can then go in and the sample one full ring old comes out in the same operation.

Top module: `dly_ring_mem`

## Requirements
- R1: After synchronous reset, `base_ptr` is 0, `rd_valid` is 0 and `req_ready` is 1.
- R2: `base_ptr` increases by one at every rising edge where `sample_tick` is high, wraps from 2^AW-1 to 0, and holds its value otherwise.
- R3: A request accepted at an edge addresses physical word (`base_ptr` + `req_ofs`) mod 2^AW. The pointer value used is the one present before that edge, even when `sample_tick` is high in the same cycle.
- R4: A single read accepted at edge k gives `rd_valid` = 1 after edge k+1 for exactly one cycle. `rd_data` is then {word, DW zero bits}.
- R5: A single write stores `req_wdata[2*DW-1:DW]` and returns the word it replaced in the same format and at the same time as R4.
- R6: A double access at offset o uses the ring address of o for the upper half and the next ring address (wrapping) for the lower half. A double write stores `req_wdata[2*DW-1:DW]` upper and `req_wdata[DW-1:0]` lower. A double access accepted at edge k gives `rd_valid` = 1 only after edge k+2, with {old upper, old lower}.
- R7: `req_ready` is 0 in the cycle after a double request is accepted. Any request presented in that cycle is ignored and changes no memory word.
- R8: A sample written at offset 0 can be read `d` ticks later at offset 2^AW-d. A write at offset 0 returns the sample written there 2^AW ticks earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sample_tick | input | 1 | Advances the base pointer by one |
| req_valid | input | 1 | Access request |
| req_ready | output | 1 | Request accepted when high |
| req_write | input | 1 | 1 = write (with read-before-write), 0 = read |
| req_dbl | input | 1 | 1 = double precision, 0 = single |
| req_ofs | input | AW | Offset relative to the base pointer |
| req_wdata | input | 2*DW | Write data; single uses the upper half |
| rd_valid | output | 1 | Result strobe |
| rd_data | output | 2*DW | Returned data |
| base_ptr | output | AW | Current base pointer |

## Verification
The bench builds the block with AW = 4 and DW = 16, which gives a 16-word ring. At that size the base pointer wraps and every offset is read at every base value in one sweep, including double accesses that straddle the top of the ring. The delay-line run covers more than one full ring of ticks. This shows that the oldest sample comes back out of a write at offset 0 and that shorter taps return the expected earlier samples.

// File: rtl/dly_ring_pkg.sv
package dly_ring_pkg;
  typedef enum logic [1:0] {
    BEAT_NONE   = 2'd0,
    BEAT_SINGLE = 2'd1,
    BEAT_HI     = 2'd2,
    BEAT_LO     = 2'd3
  } beat_e;
endpackage

// File: rtl/dly_base_ctr.sv
module dly_base_ctr #(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  output logic [AW-1:0] base
);
  always_ff @(posedge clk) begin
    if (rst)       base <= '0;
    else if (tick) base <= base + 1'b1;
  end

  // R2: one step per tick, wrapping
  a_r2_base_step: assert property (@(posedge clk) disable iff (rst)
    tick |=> (base == AW'($past(base) + 1'b1)));
  // R2: hold without tick
  a_r2_base_hold: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(base));
endmodule

// File: rtl/dly_access_seq.sv
module dly_access_seq
  import dly_ring_pkg::*;
#(
  parameter int AW = 6,
  parameter int DW = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [AW-1:0]   base,
  input  logic            req_valid,
  input  logic            req_write,
  input  logic            req_dbl,
  input  logic [AW-1:0]   req_ofs,
  input  logic [2*DW-1:0] req_wdata,
  output logic            req_ready,
  output logic            ram_en,
  output logic            ram_we,
  output logic [AW-1:0]   ram_addr,
  output logic [DW-1:0]   ram_wdata,
  output beat_e           beat
);
  logic          busy_q;
  logic [AW-1:0] lo_addr_q;
  logic [DW-1:0] lo_wdata_q;
  logic          lo_we_q;
  logic          accept;
  logic [AW-1:0] phys;

  assign req_ready = !busy_q;
  assign accept    = req_valid && !busy_q;
  assign phys      = base + req_ofs;

  always_comb begin
    ram_en    = 1'b0;
    ram_we    = 1'b0;
    ram_addr  = phys;
    ram_wdata = req_wdata[2*DW-1:DW];
    beat      = BEAT_NONE;
    if (busy_q) begin
      ram_en    = 1'b1;
      ram_we    = lo_we_q;
      ram_addr  = lo_addr_q;
      ram_wdata = lo_wdata_q;
      beat      = BEAT_LO;
    end else if (accept) begin
      ram_en = 1'b1;
      ram_we = req_write;
      beat   = req_dbl ? BEAT_HI : BEAT_SINGLE;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
    end else if (busy_q) begin
      busy_q <= 1'b0;
    end else if (accept && req_dbl) begin
      busy_q <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (accept && req_dbl) begin
      lo_addr_q  <= phys + 1'b1;
      lo_wdata_q <= req_wdata[DW-1:0];
      lo_we_q    <= req_write;
    end
  end

  // R6: second beat lands on the next ring address
  a_r6_lo_addr_next: assert property (@(posedge clk) disable iff (rst)
    (accept && req_dbl) |=> (ram_addr == AW'($past(ram_addr) + 1'b1)));
  // R7: port closed for the second beat
  a_r7_ready_drop: assert property (@(posedge clk) disable iff (rst)
    (accept && req_dbl) |=> !req_ready);
endmodule

// File: rtl/dly_ram.sv
module dly_ram #(
  parameter int AW = 6,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          en,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  // read-first single port
  always_ff @(posedge clk) begin
    if (en) begin
      rdata <= mem[addr];
      if (we) mem[addr] <= wdata;
    end
  end
endmodule

// File: rtl/dly_rd_pack.sv
module dly_rd_pack
  import dly_ring_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  beat_e           beat_in,
  input  logic [DW-1:0]   ram_q,
  output logic            rd_valid,
  output logic [2*DW-1:0] rd_data
);
  beat_e         beat_q;
  logic [DW-1:0] hi_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      beat_q   <= BEAT_NONE;
      rd_valid <= 1'b0;
    end else begin
      beat_q   <= beat_in;
      rd_valid <= (beat_q == BEAT_SINGLE) || (beat_q == BEAT_LO);
    end
  end

  always_ff @(posedge clk) begin
    case (beat_q)
      BEAT_SINGLE: rd_data <= {ram_q, {DW{1'b0}}};
      BEAT_HI:     hi_q    <= ram_q;
      BEAT_LO:     rd_data <= {hi_q, ram_q};
      default:     ;
    endcase
  end

  // R6: a pair is only released after its upper half was captured
  a_r6_pair_order: assert property (@(posedge clk) disable iff (rst)
    (beat_q == BEAT_LO) |-> ($past(beat_q) == BEAT_HI));
endmodule

// File: rtl/dly_ring_mem.sv
module dly_ring_mem
  import dly_ring_pkg::*;
#(
  parameter int AW = 6,
  parameter int DW = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            sample_tick,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic            req_write,
  input  logic            req_dbl,
  input  logic [AW-1:0]   req_ofs,
  input  logic [2*DW-1:0] req_wdata,
  output logic            rd_valid,
  output logic [2*DW-1:0] rd_data,
  output logic [AW-1:0]   base_ptr
);
  logic          ram_en;
  logic          ram_we;
  logic [AW-1:0] ram_addr;
  logic [DW-1:0] ram_wdata;
  logic [DW-1:0] ram_q;
  beat_e         beat;

  dly_base_ctr #(.AW(AW)) u_ctr (
    .clk  (clk),
    .rst  (rst),
    .tick (sample_tick),
    .base (base_ptr)
  );

  dly_access_seq #(.AW(AW), .DW(DW)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .base      (base_ptr),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_dbl   (req_dbl),
    .req_ofs   (req_ofs),
    .req_wdata (req_wdata),
    .req_ready (req_ready),
    .ram_en    (ram_en),
    .ram_we    (ram_we),
    .ram_addr  (ram_addr),
    .ram_wdata (ram_wdata),
    .beat      (beat)
  );

  dly_ram #(.AW(AW), .DW(DW)) u_ram (
    .clk   (clk),
    .en    (ram_en),
    .we    (ram_we),
    .addr  (ram_addr),
    .wdata (ram_wdata),
    .rdata (ram_q)
  );

  dly_rd_pack #(.DW(DW)) u_pack (
    .clk      (clk),
    .rst      (rst),
    .beat_in  (beat),
    .ram_q    (ram_q),
    .rd_valid (rd_valid),
    .rd_data  (rd_data)
  );

  // R4 and R5: single access answers two edges after acceptance
  a_r4_single_latency: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && !req_dbl) |=> ##1 rd_valid);
  // R6: double access answers three edges after acceptance
  a_r6_double_latency: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && req_dbl) |=> ##2 rd_valid);
endmodule

// File: tb/test_dly_ring_mem.sv
module test_dly_ring_mem;
  localparam int AW = 4;
  localparam int DW = 16;
  localparam int DEPTH = 1 << AW;
  localparam time CLK_PERIOD = 10ns;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            sample_tick = 1'b0;
  logic            req_valid = 1'b0;
  logic            req_ready;
  logic            req_write = 1'b0;
  logic            req_dbl = 1'b0;
  logic [AW-1:0]   req_ofs = '0;
  logic [2*DW-1:0] req_wdata = '0;
  logic            rd_valid;
  logic [2*DW-1:0] rd_data;
  logic [AW-1:0]   base_ptr;

  int checks = 0;
  int failures = 0;
  int base_m = 0;
  logic [DW-1:0] model [DEPTH];
  logic [DW-1:0] hist [40];

  always #(CLK_PERIOD/2) clk = ~clk;

  dly_ring_mem #(.AW(AW), .DW(DW)) i_dly_ring_mem (
    .clk, .rst, .sample_tick, .req_valid, .req_ready, .req_write,
    .req_dbl, .req_ofs, .req_wdata, .rd_valid, .rd_data, .base_ptr
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clear_req();
    req_valid = 1'b0; req_write = 1'b0; req_dbl = 1'b0;
    sample_tick = 1'b0;
  endtask

  task automatic tick();
    @(negedge clk);
    sample_tick = 1'b1;
    @(posedge clk); #1;
    clear_req();
    base_m = (base_m + 1) % DEPTH;
    check("R2 base_ptr", 32'(base_ptr), 32'(base_m));
  endtask

  task automatic single(input bit wr, input int ofs, input logic [DW-1:0] d,
                        input bit chk, input bit with_tick);
    int p;
    logic [DW-1:0] old;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_dbl = 1'b0;
    req_ofs = AW'(ofs); req_wdata = {d, 16'h5a5a}; sample_tick = with_tick;
    p = (base_m + ofs) % DEPTH;
    old = model[p];
    if (wr) model[p] = d;
    if (with_tick) base_m = (base_m + 1) % DEPTH;
    @(posedge clk); #1;
    clear_req();
    @(posedge clk); #1;
    if (chk) begin
      check(wr ? "R5 valid" : "R4 valid", 32'(rd_valid), 32'd1);
      check(with_tick ? "R3 tap" : (wr ? "R5 old word" : "R4 word"),
            rd_data, {old, 16'h0});
    end
    @(posedge clk); #1;
    if (chk) check("R4 pulse", 32'(rd_valid), 32'd0);
  endtask

  task automatic double(input bit wr, input int ofs, input logic [31:0] d,
                        input bit decoy, input int decoy_ofs);
    int p0, p1;
    logic [31:0] old;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_dbl = 1'b1;
    req_ofs = AW'(ofs); req_wdata = d;
    p0 = (base_m + ofs) % DEPTH;
    p1 = (p0 + 1) % DEPTH;
    old = {model[p0], model[p1]};
    if (wr) begin model[p0] = d[31:16]; model[p1] = d[15:0]; end
    @(posedge clk); #1;
    clear_req();
    check("R7 ready low", 32'(req_ready), 32'd0);
    if (decoy) begin
      req_valid = 1'b1; req_write = 1'b1; req_ofs = AW'(decoy_ofs);
      req_wdata = 32'hdead_beef;
    end
    @(posedge clk); #1;
    clear_req();
    check("R6 no early result", 32'(rd_valid), 32'd0);
    @(posedge clk); #1;
    check("R6 valid", 32'(rd_valid), 32'd1);
    check("R6 pair", rd_data, old);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    failures++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    check("R1 base", 32'(base_ptr), 32'd0);
    check("R1 valid", 32'(rd_valid), 32'd0);
    check("R1 ready", 32'(req_ready), 32'd1);

    // fill the ring; first contents are unknown
    for (int i = 0; i < DEPTH; i++)
      single(1'b1, i, DW'(i * 16'h1357) ^ 16'h8000, 1'b0, 1'b0);

    // every offset at every base value (R3, R4)
    for (int b = 0; b < DEPTH; b++) begin
      for (int o = 0; o < DEPTH; o++) single(1'b0, o, '0, 1'b1, 1'b0);
      tick();
    end
    check("R2 wrapped", 32'(base_ptr), 32'd0);

    // double reads at all offsets, including the top wrap (R6)
    for (int b = 0; b < 3; b++) begin
      for (int o = 0; o < DEPTH; o++) double(1'b0, o, '0, 1'b0, 0);
      tick();
    end

    // double writes, one across the wrap, with ignored requests (R6, R7)
    double(1'b1, DEPTH - 1, 32'h8001_7ffe, 1'b1, 3);
    double(1'b1, 5, 32'hffff_0000, 1'b1, 9);
    double(1'b1, DEPTH - 1, 32'h1234_abcd, 1'b0, 0);
    single(1'b0, 3, '0, 1'b1, 1'b0);
    single(1'b0, 9, '0, 1'b1, 1'b0);
    single(1'b0, DEPTH - 1, '0, 1'b1, 1'b0);
    single(1'b0, 0, '0, 1'b1, 1'b0);

    // single writes return the replaced word (R5)
    for (int o = 0; o < DEPTH; o += 3)
      single(1'b1, o, DW'(16'hc000 + o), 1'b1, 1'b0);
    single(1'b1, 2, 16'h0042, 1'b1, 1'b0);
    single(1'b1, 2, 16'hff00, 1'b1, 1'b0);

    // tick in the acceptance cycle uses the old base (R3)
    single(1'b0, 7, '0, 1'b1, 1'b1);
    check("R2 base after tick", 32'(base_ptr), 32'(base_m));
    single(1'b1, 4, 16'h7777, 1'b1, 1'b1);
    single(1'b0, 3, '0, 1'b1, 1'b0);

    // delay line: write at offset 0, read tap of three samples (R8)
    for (int n = 0; n < DEPTH + 8; n++) begin
      hist[n] = DW'(16'h2000 + n * 16'h0101);
      single(1'b1, 0, hist[n], 1'b1, 1'b0);
      if (n >= DEPTH) check("R8 full ring", rd_data, {hist[n - DEPTH], 16'h0});
      if (n >= 3) begin
        single(1'b0, DEPTH - 3, '0, 1'b1, 1'b0);
        check("R8 tap 3", rd_data, {hist[n - 3], 16'h0});
      end
      tick();
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule